// File: doc/BRIEF.md
# Private Interrupt Configuration Register File

This block is the per-core register file that holds the configuration of the banked private interrupts. There are sixteen software-generated interrupts, sixteen peripheral interrupts and a parameterised number of extended private interrupts. Software reaches the block through a simple 32-bit register bus that carries an address, write data and byte strobes. For every implemented interrupt the block stores these fields:

- an enable bit
- a group bit
- a group-modifier bit
- a priority byte
- an edge/level trigger selection
- a pending bit
- an active bit

It also holds one 32-bit non-secure access control word. All of this state is driven out on flat vectors, so that the prioritisation logic next to the block can use it.

The enable state is changed through two separate windows. One window only sets bits and the other only clears them, so software never needs a read-modify-write to change one enable. The priorities are byte-addressable, so a single priority can be written without disturbing its three neighbours in the same word. An identification word reports how many private interrupts are implemented and carries the core number, which comes in on a pin.

Top module: `pirq_regs`

## Requirements
- R1: After reset, every enable, group, group-modifier, pending, active, priority and trigger bit is zero, the access control word is zero, and `bus_ready` is low.
- R2: A request is sampled at a rising clock edge while `bus_sel` is high. `bus_ready` is high, and for a read `bus_rdata` holds the read value, during the cycle after that edge. With no request, `bus_ready` is low in the next cycle.
- R3: A write to the set-enable window (byte offset 0x1_0100, interrupt n at word n/32, bit n%32) sets each enable whose data bit is 1 and whose byte strobe is active. Data bits that are 0 leave the enable unchanged.
- R4: A write to the clear-enable window (byte offset 0x1_0180, same bit layout as R3) clears each enable whose data bit is 1 and whose byte strobe is active. Data bits that are 0 leave the enable unchanged. Reads of either window return the current enable bits.
- R5: The group bits (offset 0x1_0080) and the group-modifier bits (offset 0x1_0d00) are plain read/write, one bit per interrupt with the layout of R3, written under the byte strobes. Non-secure group 1 is group=1 with modifier=0, secure group 1 is group=0 with modifier=1, and group 0 is both bits 0.
- R6: Priority bytes start at offset 0x1_0400. Interrupt n sits in byte lane n%4 of word n/4. Each byte strobe writes only its own lane, so 8-bit and 32-bit writes both work.
- R7: The trigger words start at offset 0x1_0c00 and hold 16 interrupts per word. Bit 2*(n%16)+1 is 1 for edge and 0 for level. The even bits always read 0 and ignore writes.
- R8: The pending bits (offset 0x1_0200) and the active bits (offset 0x1_0300) are plain read/write with the layout of R3. The access control word at offset 0x1_0e00 is read/write under the byte strobes.
- R9: The identification word at offset 0x0008 reads with the count field in bits [31:27], where the implemented total is 32 + 32 × field, and with the core number input in bits [23:8]. All other bits read 0.
- R10: Words that lie past the implemented interrupt count inside any per-interrupt window read 0 and ignore writes.
- R11: Offsets that are not mapped read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_num | input | 16 | Core number reported in the identification word |
| bus_sel | input | 1 | Request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_strb | input | 4 | Byte strobes for writes |
| bus_ready | output | 1 | Request completed, one cycle after sampling |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| irq_enable | output | NUM_INT | Enable per interrupt |
| irq_group | output | NUM_INT | Group bit per interrupt |
| irq_grpmod | output | NUM_INT | Group-modifier bit per interrupt |
| irq_pending | output | NUM_INT | Pending bit per interrupt |
| irq_active | output | NUM_INT | Active bit per interrupt |
| irq_edge | output | NUM_INT | 1 = edge triggered, 0 = level |
| irq_prio | output | 8*NUM_INT | Priority bytes, interrupt n at bits [8n+7:8n] |
| ns_access | output | 32 | Non-secure access control word |

## Verification
The register windows are exercised with seeded random writes and reads. These carry random data, random byte-strobe patterns and word indices that reach one word past the implemented range, which separates correct lane masking from whole-word writes and in-range decoding from aliasing. Directed sequences write zeros and ones into the set and clear windows, which separates set/clear behaviour from plain storage. Single-lane priority writes show that the other lanes keep their values. An all-ones trigger write shows that only the odd bits are kept. A reference model kept in the bench, together with a final comparison of every state output, ties what is read over the bus to what is driven to the neighbouring logic.

// File: rtl/pirq_pkg.sv
// Shared definitions for the private interrupt register file: window
// offsets, decode result type, write kinds and strobe helpers.
// Assumes a 17-bit byte address and 32-bit data words.
package pirq_pkg;

    localparam int ADDR_W = 17;

    localparam logic [ADDR_W-1:0] OFS_IDENT  = 17'h0_0008;
    localparam logic [ADDR_W-1:0] OFS_GROUP  = 17'h1_0080;
    localparam logic [ADDR_W-1:0] OFS_SETEN  = 17'h1_0100;
    localparam logic [ADDR_W-1:0] OFS_CLREN  = 17'h1_0180;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 17'h1_0200;
    localparam logic [ADDR_W-1:0] OFS_ACT    = 17'h1_0300;
    localparam logic [ADDR_W-1:0] OFS_PRIO   = 17'h1_0400;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 17'h1_0c00;
    localparam logic [ADDR_W-1:0] OFS_GMOD   = 17'h1_0d00;
    localparam logic [ADDR_W-1:0] OFS_NSACC  = 17'h1_0e00;

    typedef enum logic [3:0] {
        RG_NONE, RG_IDENT, RG_GROUP, RG_SETEN, RG_CLREN, RG_PEND,
        RG_ACT, RG_PRIO, RG_TRIG, RG_GMOD, RG_NSACC
    } region_e;

    typedef enum logic [1:0] {
        WK_PLAIN, WK_SET, WK_CLR
    } wr_kind_e;

    typedef struct packed {
        region_e    region;
        logic [7:0] word;
    } decode_t;

    // Expand four byte strobes to a 32-bit bit mask.
    function automatic logic [31:0] strb_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{s[l]}};
        return m;
    endfunction

    // Gather the odd-numbered bits of a word (trigger select positions).
    function automatic logic [15:0] odd_bits(input logic [31:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[2*k+1];
        return r;
    endfunction

    // Map a byte address to a register window and a word index inside it.
    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.region = RG_NONE;
        d.word   = '0;
        if (a[16:2] == OFS_IDENT[16:2]) d.region = RG_IDENT;
        else if (a[16:2] == OFS_NSACC[16:2]) d.region = RG_NSACC;
        else if (a[16:7] == OFS_GROUP[16:7]) begin d.region = RG_GROUP; d.word = {3'b0, a[6:2]}; end
        else if (a[16:7] == OFS_SETEN[16:7]) begin d.region = RG_SETEN; d.word = {3'b0, a[6:2]}; end
        else if (a[16:7] == OFS_CLREN[16:7]) begin d.region = RG_CLREN; d.word = {3'b0, a[6:2]}; end
        else if (a[16:7] == OFS_PEND[16:7])  begin d.region = RG_PEND;  d.word = {3'b0, a[6:2]}; end
        else if (a[16:7] == OFS_ACT[16:7])   begin d.region = RG_ACT;   d.word = {3'b0, a[6:2]}; end
        else if (a[16:7] == OFS_GMOD[16:7])  begin d.region = RG_GMOD;  d.word = {3'b0, a[6:2]}; end
        else if (a[16:10] == OFS_PRIO[16:10]) begin d.region = RG_PRIO; d.word = a[9:2]; end
        else if (a[16:8] == OFS_TRIG[16:8])  begin d.region = RG_TRIG;  d.word = {2'b0, a[7:2]}; end
        return d;
    endfunction

endpackage

// File: rtl/pirq_bitreg.sv
// One-bit-per-interrupt register array, organised as 32-bit words.
// Supports plain masked writes, write-one-to-set and write-one-to-clear.
// Assumes NUM_INT is a multiple of 32; word indices past the array are
// ignored on write and read as zero.
module pirq_bitreg
    import pirq_pkg::*;
#(
    parameter int NUM_INT = 96,
    localparam int NUM_WORDS = NUM_INT / 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  wr_kind_e           kind,
    input  logic [7:0]         word,
    input  logic [31:0]        wdata,
    input  logic [31:0]        mask,
    output logic [31:0]        rdata,
    output logic [NUM_INT-1:0] bits
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [31:0] q;

        // Update this word according to the write kind when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && word == 8'(w)) begin
                case (kind)
                    WK_SET:  q <= q | (wdata & mask);
                    WK_CLR:  q <= q & ~(wdata & mask);
                    default: q <= (q & ~mask) | (wdata & mask);
                endcase
            end
        end

        assign bits[w*32 +: 32] = q;
    end

    // Select the addressed word for reads; out-of-range words read zero.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word == 8'(w)) rdata = bits[w*32 +: 32];
        end
    end

    // R3
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_SET && word == 8'd0 && wdata[0] && mask[0]) |=> bits[0]);

    // R4
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_CLR && word == 8'd0 && wdata[0] && mask[0]) |=> !bits[0]);

    // R3
    set_zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_SET && word == 8'd0 && !wdata[0]) |=> bits[0] == $past(bits[0]));

    // R10
    beyond_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word >= 8'(NUM_WORDS)) |=> $stable(bits));

endmodule

// File: rtl/pirq_prio.sv
// Priority byte array: one byte per interrupt, four per 32-bit word,
// interrupt n in lane n%4 of word n/4. Each byte strobe writes its lane only.
// Assumes NUM_INT is a multiple of 4.
module pirq_prio #(
    parameter int NUM_INT = 96,
    localparam int NUM_WORDS = NUM_INT / 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           word,
    input  logic [31:0]          wdata,
    input  logic [3:0]           strb,
    output logic [31:0]          rdata,
    output logic [NUM_INT*8-1:0] prio
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [31:0] q;

        // Write the strobed byte lanes of this word when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && word == 8'(w)) begin
                for (int l = 0; l < 4; l++) begin
                    if (strb[l]) q[l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end

        assign prio[w*32 +: 32] = q;
    end

    // Select the addressed priority word for reads.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word == 8'(w)) rdata = prio[w*32 +: 32];
        end
    end

    // R6
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == 8'd0 && !strb[1]) |=> $stable(prio[15:8]));

    // R6
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == 8'd0 && strb[0]) |=> prio[7:0] == $past(wdata[7:0]));

endmodule

// File: rtl/pirq_trig.sv
// Trigger selection array: 16 interrupts per word, only the odd bit of
// each two-bit field is stored (1 = edge). Even bits read zero.
// Assumes NUM_INT is a multiple of 16.
module pirq_trig #(
    parameter int NUM_INT = 96,
    localparam int NUM_WORDS = NUM_INT / 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         word,
    input  logic [15:0]        wsel,
    input  logic [15:0]        msel,
    output logic [31:0]        rdata,
    output logic [NUM_INT-1:0] edge_sel
);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [15:0] q;

        // Update the masked trigger selections of this word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && word == 8'(w)) begin
                q <= (q & ~msel) | (wsel & msel);
            end
        end

        assign edge_sel[w*16 +: 16] = q;
    end

    // Spread the addressed word's selections back to odd bit positions.
    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word == 8'(w)) begin
                for (int k = 0; k < 16; k++) rdata[2*k+1] = edge_sel[w*16 + k];
            end
        end
    end

    // R7
    trig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == 8'd0 && msel[0]) |=> edge_sel[0] == $past(wsel[0]));

endmodule

// File: rtl/pirq_regs.sv
// Top of the private interrupt register file. Decodes the register bus,
// routes writes to the bit arrays, priority and trigger stores, holds the
// access control word and registers the read data for a one-cycle ready.
// Assumes EXT_CNT in 0..2 (32, 64 or 96 private interrupts).
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int EXT_CNT = 2,
    localparam int NUM_INT = 32 + 32 * EXT_CNT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           core_num,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [3:0]            bus_strb,
    output logic                  bus_ready,
    output logic [31:0]           bus_rdata,
    output logic [NUM_INT-1:0]    irq_enable,
    output logic [NUM_INT-1:0]    irq_group,
    output logic [NUM_INT-1:0]    irq_grpmod,
    output logic [NUM_INT-1:0]    irq_pending,
    output logic [NUM_INT-1:0]    irq_active,
    output logic [NUM_INT-1:0]    irq_edge,
    output logic [NUM_INT*8-1:0]  irq_prio,
    output logic [31:0]           ns_access
);

    decode_t     dec;
    logic        wr_go;
    logic [31:0] wmask;
    logic [31:0] en_rd, grp_rd, gmod_rd, pend_rd, act_rd, prio_rd, trig_rd;
    logic [31:0] rd_next;
    logic [31:0] ident_word;
    wr_kind_e    en_kind;
    logic        unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[1:0];
    assign dec        = decode_addr(bus_addr);
    assign wr_go      = bus_sel && bus_wr;
    assign wmask      = strb_mask(bus_strb);
    assign en_kind    = (dec.region == RG_SETEN) ? WK_SET : WK_CLR;
    assign ident_word = {5'(EXT_CNT), 3'b000, core_num, 8'h00};

    pirq_bitreg #(.NUM_INT(NUM_INT)) u_enable (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go && (dec.region == RG_SETEN || dec.region == RG_CLREN)),
        .kind(en_kind), .word(dec.word), .wdata(bus_wdata), .mask(wmask),
        .rdata(en_rd), .bits(irq_enable));

    pirq_bitreg #(.NUM_INT(NUM_INT)) u_group (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_GROUP),
        .kind(WK_PLAIN), .word(dec.word), .wdata(bus_wdata), .mask(wmask),
        .rdata(grp_rd), .bits(irq_group));

    pirq_bitreg #(.NUM_INT(NUM_INT)) u_grpmod (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_GMOD),
        .kind(WK_PLAIN), .word(dec.word), .wdata(bus_wdata), .mask(wmask),
        .rdata(gmod_rd), .bits(irq_grpmod));

    pirq_bitreg #(.NUM_INT(NUM_INT)) u_pending (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_PEND),
        .kind(WK_PLAIN), .word(dec.word), .wdata(bus_wdata), .mask(wmask),
        .rdata(pend_rd), .bits(irq_pending));

    pirq_bitreg #(.NUM_INT(NUM_INT)) u_active (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_ACT),
        .kind(WK_PLAIN), .word(dec.word), .wdata(bus_wdata), .mask(wmask),
        .rdata(act_rd), .bits(irq_active));

    pirq_prio #(.NUM_INT(NUM_INT)) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_PRIO),
        .word(dec.word), .wdata(bus_wdata), .strb(bus_strb),
        .rdata(prio_rd), .prio(irq_prio));

    pirq_trig #(.NUM_INT(NUM_INT)) u_trig (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && dec.region == RG_TRIG),
        .word(dec.word), .wsel(odd_bits(bus_wdata)), .msel(odd_bits(wmask)),
        .rdata(trig_rd), .edge_sel(irq_edge));

    // Hold the access control word, written under the byte strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_access <= '0;
        end else if (wr_go && dec.region == RG_NSACC) begin
            ns_access <= (ns_access & ~wmask) | (bus_wdata & wmask);
        end
    end

    // Choose the read value of the addressed window.
    always_comb begin
        case (dec.region)
            RG_IDENT:           rd_next = ident_word;
            RG_GROUP:           rd_next = grp_rd;
            RG_SETEN, RG_CLREN: rd_next = en_rd;
            RG_PEND:            rd_next = pend_rd;
            RG_ACT:             rd_next = act_rd;
            RG_PRIO:            rd_next = prio_rd;
            RG_TRIG:            rd_next = trig_rd;
            RG_GMOD:            rd_next = gmod_rd;
            RG_NSACC:           rd_next = ns_access;
            default:            rd_next = '0;
        endcase
    end

    // Register ready and read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            bus_rdata <= (bus_sel && !bus_wr) ? rd_next : '0;
        end
    end

    // R2
    ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ready);

    // R9
    ident_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_IDENT) |=> bus_rdata[23:8] == $past(core_num));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && dec.region == RG_NONE) |=> bus_rdata == 32'h0);

    // R8
    nsacc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && dec.region == RG_NSACC) |=> $stable(ns_access));

endmodule

// File: tb/pirq_regs_tb.sv
module pirq_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       core_num = 16'hcd01;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [16:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [3:0]        bus_strb = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic [NI-1:0]     irq_enable, irq_group, irq_grpmod, irq_pending, irq_active, irq_edge;
    logic [NI*8-1:0]   irq_prio;
    logic [31:0]       ns_access;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [NI-1:0] m_en, m_grp, m_gmod, m_pend, m_act, m_edge;
    logic [7:0]    m_prio [NI];
    logic [31:0]   m_nsac;

    always #(CLK_PERIOD/2) clk = ~clk;

    pirq_regs #(.EXT_CNT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .core_num(core_num),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_strb(bus_strb),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .irq_enable(irq_enable), .irq_group(irq_group), .irq_grpmod(irq_grpmod),
        .irq_pending(irq_pending), .irq_active(irq_active), .irq_edge(irq_edge),
        .irq_prio(irq_prio), .ns_access(ns_access));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] smask(input logic [3:0] s);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = s[l] ? 8'hff : 8'h00;
        return m;
    endfunction

    // kind: 0 plain, 1 set, 2 clear
    function automatic logic [NI-1:0] upd(input logic [NI-1:0] v, input int w,
                                          input logic [31:0] d, input logic [31:0] m, input int kind);
        logic [NI-1:0] r = v;
        if (w < NI/32) begin
            for (int b = 0; b < 32; b++) begin
                if (m[b]) begin
                    if (kind == 0) r[w*32+b] = d[b];
                    else if (kind == 1 && d[b]) r[w*32+b] = 1'b1;
                    else if (kind == 2 && d[b]) r[w*32+b] = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] rdv(input logic [NI-1:0] v, input int w);
        return (w < NI/32) ? v[w*32 +: 32] : 32'h0;
    endfunction

    function automatic bit inwin(input logic [16:0] a, input logic [16:0] base, input int bytes);
        return (a >= base) && (int'(a) < int'(base) + bytes);
    endfunction

    task automatic mdl_write(input logic [16:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] m = smask(s);
        if (inwin(a, 17'h10080, 128)) m_grp  = upd(m_grp,  int'(a - 17'h10080) / 4, d, m, 0);
        if (inwin(a, 17'h10100, 128)) m_en   = upd(m_en,   int'(a - 17'h10100) / 4, d, m, 1);
        if (inwin(a, 17'h10180, 128)) m_en   = upd(m_en,   int'(a - 17'h10180) / 4, d, m, 2);
        if (inwin(a, 17'h10200, 128)) m_pend = upd(m_pend, int'(a - 17'h10200) / 4, d, m, 0);
        if (inwin(a, 17'h10300, 128)) m_act  = upd(m_act,  int'(a - 17'h10300) / 4, d, m, 0);
        if (inwin(a, 17'h10d00, 128)) m_gmod = upd(m_gmod, int'(a - 17'h10d00) / 4, d, m, 0);
        if (inwin(a, 17'h10400, 1024)) begin
            int w = int'(a - 17'h10400) / 4;
            if (w < NI/4) for (int l = 0; l < 4; l++) if (s[l]) m_prio[w*4+l] = d[l*8 +: 8];
        end
        if (inwin(a, 17'h10c00, 256)) begin
            int w = int'(a - 17'h10c00) / 4;
            if (w < NI/16) for (int k = 0; k < 16; k++) if (m[2*k+1]) m_edge[w*16+k] = d[2*k+1];
        end
        if (inwin(a, 17'h10e00, 4)) m_nsac = (m_nsac & ~m) | (d & m);
    endtask

    function automatic logic [31:0] mdl_read(input logic [16:0] a);
        logic [31:0] r = 32'h0;
        if (inwin(a, 17'h00008, 4)) r = {5'd2, 3'b0, core_num, 8'h00};
        if (inwin(a, 17'h10080, 128)) r = rdv(m_grp,  int'(a - 17'h10080) / 4);
        if (inwin(a, 17'h10100, 128)) r = rdv(m_en,   int'(a - 17'h10100) / 4);
        if (inwin(a, 17'h10180, 128)) r = rdv(m_en,   int'(a - 17'h10180) / 4);
        if (inwin(a, 17'h10200, 128)) r = rdv(m_pend, int'(a - 17'h10200) / 4);
        if (inwin(a, 17'h10300, 128)) r = rdv(m_act,  int'(a - 17'h10300) / 4);
        if (inwin(a, 17'h10d00, 128)) r = rdv(m_gmod, int'(a - 17'h10d00) / 4);
        if (inwin(a, 17'h10400, 1024)) begin
            int w = int'(a - 17'h10400) / 4;
            if (w < NI/4) r = {m_prio[w*4+3], m_prio[w*4+2], m_prio[w*4+1], m_prio[w*4]};
        end
        if (inwin(a, 17'h10c00, 256)) begin
            int w = int'(a - 17'h10c00) / 4;
            if (w < NI/16) for (int k = 0; k < 16; k++) r[2*k+1] = m_edge[w*16+k];
        end
        if (inwin(a, 17'h10e00, 4)) r = m_nsac;
        return r;
    endfunction

    task automatic bus_op(input logic wr, input logic [16:0] a, input logic [31:0] d,
                          input logic [3:0] s, output logic [31:0] rd, output logic rdy);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_strb = s;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd = bus_rdata; rdy = bus_ready;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] rd; logic rdy;
        bus_op(1'b1, a, d, s, rd, rdy);
        mdl_write(a, d, s);
    endtask

    task automatic do_read(input logic [16:0] a, output logic [31:0] rd);
        logic rdy;
        bus_op(1'b0, a, 32'h0, 4'h0, rd, rdy);
    endtask

    task automatic read_chk(input string req, input logic [16:0] a, input logic [31:0] exp);
        logic [31:0] rd;
        do_read(a, rd);
        chk(req, rd, exp);
    endtask

    initial begin
        logic [31:0] rd;
        logic rdy;
        int dummy;
        m_en = '0; m_grp = '0; m_gmod = '0; m_pend = '0; m_act = '0; m_edge = '0; m_nsac = '0;
        for (int i = 0; i < NI; i++) m_prio[i] = 8'h00;
        dummy = $urandom(32'd2024);

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready low", {31'b0, bus_ready}, 32'h0);
        chk("R1 enables", irq_enable[31:0] | irq_pending[31:0] | irq_active[31:0], 32'h0);
        chk("R1 prio/nsac", irq_prio[31:0] | ns_access, 32'h0);
        read_chk("R1 edge word", 17'h10c00, 32'h0);

        // R9 identification word
        read_chk("R9 ident", 17'h00008, 32'h10cd_0100);

        // R3 set window
        do_write(17'h10100, 32'h0000_0005, 4'hf);
        read_chk("R3 set", 17'h10100, 32'h0000_0005);
        do_write(17'h10100, 32'h0000_0000, 4'hf);
        read_chk("R3 zero no effect", 17'h10100, 32'h0000_0005);
        do_write(17'h10100, 32'h0000_0202, 4'h1);
        read_chk("R3 strobe", 17'h10100, 32'h0000_0007);

        // R4 clear window
        do_write(17'h10180, 32'h0000_0004, 4'hf);
        read_chk("R4 clear read via clear window", 17'h10180, 32'h0000_0003);
        chk("R4 enable outputs", {29'b0, irq_enable[2:0]}, 32'h3);

        // R6 byte-lane priorities
        do_write(17'h10400, 32'h0000_00ab, 4'h1);
        do_write(17'h10400, 32'hcd00_00ff, 4'h8);
        read_chk("R6 lanes", 17'h10400, 32'hcd00_00ab);
        chk("R6 prio output", {24'b0, irq_prio[7:0]}, 32'hab);
        do_write(17'h1045c, 32'h7800_0000, 4'h8);
        read_chk("R6 last interrupt", 17'h1045c, 32'h7800_0000);

        // R7 trigger odd bits only
        do_write(17'h10c00, 32'hffff_ffff, 4'hf);
        read_chk("R7 even bits zero", 17'h10c00, 32'haaaa_aaaa);
        chk("R7 edge outputs", {16'b0, irq_edge[15:0]}, 32'hffff);

        // R5 group and modifier
        do_write(17'h10080, 32'h0000_0001, 4'hf);
        do_write(17'h10d00, 32'h0000_0002, 4'hf);
        chk("R5 group/modifier", {30'b0, irq_grpmod[1], irq_group[0]}, 32'h3);
        read_chk("R5 modifier read", 17'h10d00, 32'h0000_0002);

        // R8 pending, active, access word
        do_write(17'h10204, 32'h8000_0000, 4'hf);
        chk("R8 pending out", {31'b0, irq_pending[63]}, 32'h1);
        do_write(17'h10e00, 32'h1234_5678, 4'h3);
        read_chk("R8 access word", 17'h10e00, 32'h0000_5678);

        // R10 beyond implemented
        do_write(17'h1010c, 32'hffff_ffff, 4'hf);
        read_chk("R10 enable word 3", 17'h1010c, 32'h0);
        do_write(17'h10460, 32'hffff_ffff, 4'hf);
        read_chk("R10 prio word 24", 17'h10460, 32'h0);
        chk("R10 enables unchanged", irq_enable[95:64] | irq_enable[63:32], 32'h0);

        // R11 unmapped
        do_write(17'h10010, 32'hffff_ffff, 4'hf);
        read_chk("R11 unmapped", 17'h10010, 32'h0);

        // R2 handshake timing
        bus_op(1'b0, 17'h10100, 32'h0, 4'h0, rd, rdy);
        chk("R2 ready after request", {31'b0, rdy}, 32'h1);
        chk("R2 data with ready", rd, 32'h0000_0003);
        @(negedge clk);
        chk("R2 ready drops when idle", {31'b0, bus_ready}, 32'h0);

        // Random phase across all windows (R3..R8, R10, R11)
        for (int i = 0; i < 600; i++) begin
            logic [16:0] a;
            int r = $urandom % 11;
            case (r)
                0: a = 17'h10080 + 17'(($urandom % 4) * 4);
                1: a = 17'h10100 + 17'(($urandom % 4) * 4);
                2: a = 17'h10180 + 17'(($urandom % 4) * 4);
                3: a = 17'h10200 + 17'(($urandom % 4) * 4);
                4: a = 17'h10300 + 17'(($urandom % 4) * 4);
                5: a = 17'h10d00 + 17'(($urandom % 4) * 4);
                6: a = 17'h10400 + 17'(($urandom % 25) * 4);
                7: a = 17'h10c00 + 17'(($urandom % 7) * 4);
                8: a = 17'h10e00;
                9: a = 17'h00008;
                default: a = 17'(($urandom % 32768) * 4) & 17'h1_0ffc;
            endcase
            if ($urandom % 2 == 0) do_write(a, $urandom, 4'($urandom));
            else begin
                do_read(a, rd);
                chk($sformatf("R3-R11 random read %05h", a), rd, mdl_read(a));
            end
        end

        // Final output comparison
        chk("R3 enable out lo", irq_enable[31:0], m_en[31:0]);
        chk("R4 enable out hi", irq_enable[95:64], m_en[95:64]);
        chk("R5 group out", irq_group[63:32], m_grp[63:32]);
        chk("R5 modifier out", irq_grpmod[31:0], m_gmod[31:0]);
        chk("R8 pending out", irq_pending[95:64], m_pend[95:64]);
        chk("R8 active out", irq_active[31:0], m_act[31:0]);
        chk("R7 edge out", irq_edge[95:64], m_edge[95:64]);
        chk("R8 access out", ns_access, m_nsac);
        for (int i = 0; i < NI; i++) chk("R6 prio out", {24'b0, irq_prio[i*8 +: 8]}, {24'b0, m_prio[i]});

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule